// File: doc/BRIEF.md
# Vector four-way dot-product accumulator

This datapath block updates an accumulator vector with unsigned dot products. Each accumulator lane is paired with a group of four narrow unsigned sub-elements at the same position in each of two source vectors. The four pairs are multiplied, the products are summed, and the sum is added to the lane. Every lane of the vector is updated on every operation. The returned vector replaces the accumulator operand completely.

A two-bit size code chooses the lane geometry. In one setting the block uses 32-bit lanes built from 8-bit sub-elements. In the other it uses 64-bit lanes built from 16-bit sub-elements. The same array of 8×8 multipliers serves both geometries. In 16-bit mode, four byte partial products are combined into each 16×16 product.

Operations enter through a valid/ready handshake and leave after a fixed two-stage pipeline. The output side has its own valid/ready pair, and a stalled output holds the whole pipe. A size code outside the two legal settings still produces an output beat. That beat raises an illegal flag, and the result bus keeps its previous value.

Top module: `vdot4_acc`

## Requirements
- R1: Size code 2'b10 selects 32-bit lanes with 8-bit sub-elements, and size code 2'b11 selects 64-bit lanes with 16-bit sub-elements.
- R2: Lane e (counted from bit 0 at lane width W) uses sub-elements 4e, 4e+1, 4e+2 and 4e+3 of each source, where sub-element j occupies bits [j*W/4 +: W/4].
- R3: Sub-elements are unsigned, and every product is zero-extended to the lane width before it is added.
- R4: Each lane's result is the accumulator lane plus the four products, reduced modulo 2^W, so any carry out of the lane is lost.
- R5: Every lane of `out_result` is recomputed on each legal operation. The result depends only on that operation's three operands.
- R6: `VLEN` must be a positive multiple of 64, and the result holds VLEN/W lanes.
- R7: A size code whose upper bit is 0 (2'b00 or 2'b01) gives an output beat with `out_illegal`=1, and `out_result` keeps its previous value. A legal beat has `out_illegal`=0.
- R8: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after the second following edge. One operation can be accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` hold steady and `in_ready` is low.
- R10: Synchronous active-high reset clears `out_valid` and the internal stage valid bit, so `in_ready` is high after reset. Reset does not clear the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_size | input | 2 | Lane geometry code (2'b10 = 32/8, 2'b11 = 64/16, other values illegal) |
| in_src_a | input | VLEN | First source vector |
| in_src_b | input | VLEN | Second source vector |
| in_acc | input | VLEN | Accumulator operand |
| out_ready | input | 1 | Consumer takes the output beat |
| out_valid | output | 1 | Output beat present |
| out_illegal | output | 1 | Beat came from an illegal size code |
| out_result | output | VLEN | Updated accumulator vector |

## Verification
The bench drives operands of all-ones into an all-ones accumulator in both geometries. A design that kept the carry or added at the wrong width would return a value other than the wrapped sum. It uses 16-bit sub-elements whose upper bytes are non-zero, so that dropping or misaligning a cross partial product shows up as a wrong 64-bit lane. Distinct per-position values expose any lane that reads the wrong group of four. Illegal codes come straight after legal results, which catches a design that writes garbage or clears the bus. A stalled output with a second operation queued behind it catches a pipe that overwrites or drops a beat.

// File: rtl/vdot4_pkg.sv
package vdot4_pkg;
   localparam int SLICE_W       = 64;
   localparam int BYTE_W        = 8;
   localparam int PP_W          = 2 * BYTE_W;
   localparam int HALVES        = SLICE_W / PP_W;
   localparam int PP_PER_HALF   = 4;
   localparam int PP_PER_SLICE  = HALVES * PP_PER_HALF;
   localparam int PP_SLICE_W    = PP_PER_SLICE * PP_W;
   localparam int NARROW_LANE_W = 32;

   localparam logic [1:0] SZ_W32 = 2'b10;
   localparam logic [1:0] SZ_W64 = 2'b11;

   // partial-product slot k inside one 16-bit half:
   // 0 = lo*lo, 1 = hi*hi, 2 = lo(a)*hi(b), 3 = hi(a)*lo(b)
   localparam int PK_LL = 0;
   localparam int PK_HH = 1;
   localparam int PK_LH = 2;
   localparam int PK_HL = 3;
endpackage

// File: rtl/vdot4_mul8.sv
module vdot4_mul8 #(
   parameter int W = 8
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   localparam int PW = 2 * W;
   assign p = PW'(x) * PW'(y);
endmodule

// File: rtl/vdot4_pp_slice.sv
module vdot4_pp_slice
   import vdot4_pkg::*;
(
   input  logic [SLICE_W-1:0]    a,
   input  logic [SLICE_W-1:0]    b,
   input  logic                  half,
   output logic [PP_SLICE_W-1:0] pp
);
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [BYTE_W-1:0] a_lo, a_hi, b_lo, b_hi;
      assign a_lo = a[h*PP_W          +: BYTE_W];
      assign a_hi = a[h*PP_W + BYTE_W +: BYTE_W];
      assign b_lo = b[h*PP_W          +: BYTE_W];
      assign b_hi = b[h*PP_W + BYTE_W +: BYTE_W];

      for (genvar k = 0; k < PP_PER_HALF; k++) begin : g_pp
         logic [BYTE_W-1:0] x, y;
         logic [PP_W-1:0]   m;
         assign x = (k == PK_LL || k == PK_LH) ? a_lo : a_hi;
         assign y = (k == PK_LL || k == PK_HL) ? b_lo : b_hi;

         vdot4_mul8 #(.W(BYTE_W)) u_mul (.x(x), .y(y), .p(m));

         if (k == PK_LH || k == PK_HL) begin : g_cross
            // cross terms only matter for 16-bit sub-elements; gate them otherwise
            assign pp[(h*PP_PER_HALF + k)*PP_W +: PP_W] = half ? m : '0;
         end else begin : g_diag
            assign pp[(h*PP_PER_HALF + k)*PP_W +: PP_W] = m;
         end
      end
   end
endmodule

// File: rtl/vdot4_red_slice.sv
module vdot4_red_slice
   import vdot4_pkg::*;
(
   input  logic [PP_SLICE_W-1:0] pp,
   input  logic [SLICE_W-1:0]    acc,
   input  logic                  half,
   output logic [SLICE_W-1:0]    res
);
   localparam int NLANE_NARROW = SLICE_W / NARROW_LANE_W;
   localparam int HALVES_PER_NARROW = HALVES / NLANE_NARROW;

   always_comb begin
      logic [SLICE_W-1:0]       dot;
      logic [SLICE_W-1:0]       prod;
      logic [NARROW_LANE_W-1:0] lane;
      logic [SLICE_W-1:0]       narrow;
      dot    = '0;
      narrow = '0;
      for (int h = 0; h < HALVES; h++) begin
         prod = SLICE_W'({pp[(h*PP_PER_HALF + PK_HH)*PP_W +: PP_W],
                          pp[(h*PP_PER_HALF + PK_LL)*PP_W +: PP_W]})
              + (SLICE_W'(pp[(h*PP_PER_HALF + PK_LH)*PP_W +: PP_W]) << BYTE_W)
              + (SLICE_W'(pp[(h*PP_PER_HALF + PK_HL)*PP_W +: PP_W]) << BYTE_W);
         dot  = dot + prod;
      end
      for (int l = 0; l < NLANE_NARROW; l++) begin
         lane = acc[l*NARROW_LANE_W +: NARROW_LANE_W];
         for (int h = l*HALVES_PER_NARROW; h < (l+1)*HALVES_PER_NARROW; h++) begin
            lane = lane + NARROW_LANE_W'(pp[(h*PP_PER_HALF + PK_LL)*PP_W +: PP_W])
                        + NARROW_LANE_W'(pp[(h*PP_PER_HALF + PK_HH)*PP_W +: PP_W]);
         end
         narrow[l*NARROW_LANE_W +: NARROW_LANE_W] = lane;
      end
      res = half ? (acc + dot) : narrow;
   end
endmodule

// File: rtl/vdot4_acc.sv
module vdot4_acc
   import vdot4_pkg::*;
#(
   parameter int VLEN = 128
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [1:0]      in_size,
   input  logic [VLEN-1:0] in_src_a,
   input  logic [VLEN-1:0] in_src_b,
   input  logic [VLEN-1:0] in_acc,
   input  logic            out_ready,
   output logic            out_valid,
   output logic            out_illegal,
   output logic [VLEN-1:0] out_result
);
   localparam int NSLICE = VLEN / SLICE_W;
   localparam int PPW    = NSLICE * PP_SLICE_W;

   if (VLEN <= 0 || VLEN % SLICE_W != 0) begin : g_bad_vlen
      $error("vdot4_acc: VLEN must be a positive multiple of 64");
   end

   logic            adv, take, is_half, is_legal;
   logic [PPW-1:0]  pp_c;
   logic [VLEN-1:0] res_c;

   logic            s1_vld, s1_half, s1_ill;
   logic [PPW-1:0]  s1_pp;
   logic [VLEN-1:0] s1_acc;

   logic            s2_vld, s2_ill;
   logic [VLEN-1:0] s2_res;

   assign adv      = !s2_vld || out_ready;
   assign in_ready = adv;
   assign take     = in_valid && adv;
   assign is_legal = in_size[1];
   assign is_half  = in_size[0];

   // stage 1: byte partial products
   for (genvar s = 0; s < NSLICE; s++) begin : g_pp
      vdot4_pp_slice u_pp (
         .a    (in_src_a[s*SLICE_W +: SLICE_W]),
         .b    (in_src_b[s*SLICE_W +: SLICE_W]),
         .half (is_half),
         .pp   (pp_c[s*PP_SLICE_W +: PP_SLICE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)      s1_vld <= 1'b0;
      else if (adv) s1_vld <= take;
   end

   always_ff @(posedge clk) begin
      if (take) begin
         s1_pp   <= pp_c;
         s1_acc  <= in_acc;
         s1_half <= is_half;
         s1_ill  <= !is_legal;
      end
   end

   // stage 2: combine, sum and accumulate
   for (genvar s = 0; s < NSLICE; s++) begin : g_red
      vdot4_red_slice u_red (
         .pp   (s1_pp[s*PP_SLICE_W +: PP_SLICE_W]),
         .acc  (s1_acc[s*SLICE_W +: SLICE_W]),
         .half (s1_half),
         .res  (res_c[s*SLICE_W +: SLICE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)      s2_vld <= 1'b0;
      else if (adv) s2_vld <= s1_vld;
   end

   always_ff @(posedge clk) begin
      if (adv && s1_vld) s2_ill <= s1_ill;
      if (adv && s1_vld && !s1_ill) s2_res <= res_c;
   end

   assign out_valid   = s2_vld;
   assign out_illegal = s2_vld && s2_ill;
   assign out_result  = s2_res;

   AST_ACCEPT_TO_S1: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> s1_vld) else $error("accepted op not in stage 1"); // R8
   AST_S1_TO_OUT: assert property (@(posedge clk) disable iff (rst) (s1_vld && in_ready) |=> out_valid) else $error("stage 1 op not at output"); // R8
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal))) else $error("stalled beat changed"); // R9
   AST_ILLEGAL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst) (in_ready && s1_vld && s1_ill) |=> (out_illegal && $stable(out_result))) else $error("illegal op touched result"); // R7
   AST_LEGAL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst) (in_ready && s1_vld && !s1_ill) |=> (out_valid && !out_illegal)) else $error("legal op flagged"); // R7
   AST_RESET_FLUSH: assert property (@(posedge clk) rst |=> (!out_valid && !s1_vld)) else $error("reset left a valid beat"); // R10
endmodule

// File: tb/vdot4_acc_bench.sv
module vdot4_acc_bench;
   localparam int VLEN = 128;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [1:0]      in_size = 2'b10;
   logic [VLEN-1:0] in_src_a = '0, in_src_b = '0, in_acc = '0;
   logic            out_ready = 1'b1;
   logic            out_valid, out_illegal;
   logic [VLEN-1:0] out_result;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;
   logic [VLEN-1:0] last_res = '0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #10 clk = ~clk;

   vdot4_acc #(.VLEN(VLEN)) u_vdot4_acc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_size(in_size), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
      .out_ready(out_ready), .out_valid(out_valid), .out_illegal(out_illegal),
      .out_result(out_result)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [VLEN-1:0] model(input logic half, input logic [VLEN-1:0] a,
                                             input logic [VLEN-1:0] b, input logic [VLEN-1:0] c);
      logic [VLEN-1:0] r = '0;
      if (!half) begin
         for (int e = 0; e < VLEN/32; e++) begin
            logic [31:0] s = c[e*32 +: 32];
            for (int i = 0; i < 4; i++)
               s = s + 32'(a[(4*e+i)*8 +: 8]) * 32'(b[(4*e+i)*8 +: 8]);
            r[e*32 +: 32] = s;
         end
      end else begin
         for (int e = 0; e < VLEN/64; e++) begin
            logic [63:0] s = c[e*64 +: 64];
            for (int i = 0; i < 4; i++)
               s = s + 64'(a[(4*e+i)*16 +: 16]) * 64'(b[(4*e+i)*16 +: 16]);
            r[e*64 +: 64] = s;
         end
      end
      return r;
   endfunction

   function automatic logic [VLEN-1:0] rnd_vec();
      logic [VLEN-1:0] v;
      for (int w = 0; w < VLEN/64; w++) begin
         rng = rng ^ (rng << 13);
         rng = rng ^ (rng >> 7);
         rng = rng ^ (rng << 17);
         v[w*64 +: 64] = rng;
      end
      return v;
   endfunction

   // one operation with a free output; checks latency, flag and result
   task automatic run_op(input logic [1:0] sz, input logic [VLEN-1:0] a,
                         input logic [VLEN-1:0] b, input logic [VLEN-1:0] c, input string req);
      logic ill = !sz[1];
      logic [VLEN-1:0] exp = ill ? last_res : model(sz[0], a, b, c);
      @(negedge clk);
      in_valid = 1'b1; in_size = sz; in_src_a = a; in_src_b = b; in_acc = c;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b0, "R8", "out_valid one cycle after accept", VLEN'(out_valid), '0);
      @(negedge clk);
      check(out_valid === 1'b1, "R8", "out_valid two cycles after accept", VLEN'(out_valid), 1);
      check(out_illegal === ill, "R7", "illegal flag", VLEN'(out_illegal), VLEN'(ill));
      check(out_result === exp, req, "result", out_result, exp);
      if (!ill) last_res = exp;
   endtask

   task automatic t_reset();
      check(out_valid === 1'b0, "R10", "out_valid after reset", VLEN'(out_valid), '0);
      check(in_ready === 1'b1, "R10", "in_ready after reset", VLEN'(in_ready), 1);
   endtask

   task automatic t_byte_order();
      logic [VLEN-1:0] a, b;
      for (int i = 0; i < VLEN/8; i++) begin a[i*8 +: 8] = 8'(i+1); b[i*8 +: 8] = 8'd1; end
      run_op(2'b10, a, b, '0, "R2");
      // lane e = sum of (i+1) for i = 4e..4e+3 = 16e+10
      for (int e = 0; e < VLEN/32; e++)
         check(out_result[e*32 +: 32] === 32'(16*e+10), "R1", "byte lane value",
               VLEN'(out_result[e*32 +: 32]), VLEN'(16*e+10));
   endtask

   task automatic t_byte_wrap();
      run_op(2'b10, '1, '1, '1, "R4");
      // 4*255*255 + 2^32-1 wraps to 260099
      check(out_result[31:0] === 32'd260099, "R3", "byte wrap lane 0",
            VLEN'(out_result[31:0]), VLEN'(260099));
   endtask

   task automatic t_half_order();
      logic [VLEN-1:0] a, b, c;
      for (int i = 0; i < VLEN/16; i++) begin a[i*16 +: 16] = 16'(i+1); b[i*16 +: 16] = 16'(i%4+1); end
      c = '0; c[63:0] = 64'd100;
      run_op(2'b11, a, b, c, "R2");
      check(out_result[63:0] === 64'd130, "R2", "half lane 0", VLEN'(out_result[63:0]), VLEN'(130));
      check(out_result[127:64] === 64'd70, "R2", "half lane 1", VLEN'(out_result[127:64]), VLEN'(70));
   endtask

   task automatic t_half_wrap();
      run_op(2'b11, '1, '1, '1, "R4");
      // 4*65535^2 - 1 = 17179344899 after wrap
      check(out_result[63:0] === 64'd17179344899, "R3", "half wrap lane 0",
            VLEN'(out_result[63:0]), VLEN'(64'd17179344899));
   endtask

   task automatic t_random();
      for (int k = 0; k < 24; k++) begin
         logic [VLEN-1:0] a = rnd_vec(), b = rnd_vec(), c = rnd_vec();
         run_op({1'b1, 1'(k % 2)}, a, b, c, "R5"); // R6: all VLEN/W lanes compared
      end
   endtask

   task automatic t_illegal();
      run_op(2'b00, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
      run_op(2'b01, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
      run_op(2'b10, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
   endtask

   task automatic t_back_to_back();
      logic [VLEN-1:0] a1 = rnd_vec(), b1 = rnd_vec(), c1 = rnd_vec();
      logic [VLEN-1:0] a2 = rnd_vec(), b2 = rnd_vec(), c2 = rnd_vec();
      logic [VLEN-1:0] e1 = model(1'b0, a1, b1, c1), e2 = model(1'b1, a2, b2, c2);
      @(negedge clk);
      in_valid = 1'b1; in_size = 2'b10; in_src_a = a1; in_src_b = b1; in_acc = c1;
      @(negedge clk);
      check(in_ready === 1'b1, "R8", "ready for second op", VLEN'(in_ready), 1);
      in_size = 2'b11; in_src_a = a2; in_src_b = b2; in_acc = c2;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1 && out_result === e1, "R8", "first of pair", out_result, e1);
      @(negedge clk);
      check(out_valid === 1'b1 && out_result === e2, "R8", "second of pair", out_result, e2);
      @(negedge clk);
      check(out_valid === 1'b0, "R8", "pipe empty after pair", VLEN'(out_valid), '0);
      last_res = e2;
   endtask

   task automatic t_stall();
      logic [VLEN-1:0] a1 = rnd_vec(), b1 = rnd_vec(), c1 = rnd_vec();
      logic [VLEN-1:0] a2 = rnd_vec(), b2 = rnd_vec(), c2 = rnd_vec();
      logic [VLEN-1:0] e1 = model(1'b1, a1, b1, c1), e2 = model(1'b0, a2, b2, c2);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_size = 2'b11; in_src_a = a1; in_src_b = b1; in_acc = c1;
      @(negedge clk);
      in_size = 2'b10; in_src_a = a2; in_src_b = b2; in_acc = c2;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check(out_valid === 1'b1 && out_result === e1, "R9", "held beat", out_result, e1);
         check(in_ready === 1'b0, "R9", "in_ready low while stalled", VLEN'(in_ready), '0);
         @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b1 && out_result === e2, "R9", "queued beat after release", out_result, e2);
      @(negedge clk);
      check(out_valid === 1'b0, "R9", "pipe empty after release", VLEN'(out_valid), '0);
      last_res = e2;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_byte_order();
      t_byte_wrap();
      t_half_order();
      t_half_wrap();
      t_random();
      t_illegal();
      t_back_to_back();
      t_stall();
      t_illegal();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule